// File: doc/BRIEF.md
# Inter-Subarray Row Copy Sequencer

This block drives the command stream that copies one full row of a DRAM bank into a row of another subarray of the same bank. The bitlines of neighbouring subarrays can be joined by link transistors, so a latched row buffer can be shifted sideways into the next subarray's buffer. The row never passes over the narrow internal data bus. A copy therefore reads as a short program. The sequencer opens the source row. It then pushes the latched buffer hop by hop toward the destination subarray, closing each receiving buffer just before it is filled. It opens the destination row so that the buffer contents are written into the cells. Finally it closes every buffer it touched.

A requester presents source and destination subarray and row indices with a valid strobe. The block accepts one copy at a time and emits one command per cycle at most on a small command bus. Each command waits for a programmable span before the next one goes out: one span for activation, one for precharge, one for a link hop. Busy covers the whole copy. A one-cycle done pulse ends it, and a copy whose two subarrays are the same is refused with a one-cycle error pulse.

Top module: `rowcopy_seq`

## Requirements
- R1: `req_ready` equals the inverse of `busy`. A request presented while busy is ignored: it changes neither the command stream nor the done timing of the copy in progress.
- R2: A request whose source and destination subarrays are equal raises `err` for exactly one cycle, the cycle after the accepting edge. No command is issued and `busy` stays low.
- R3: On an accepted copy, `busy` rises and an activate of the source subarray and row appears on the command bus in the cycle after the accepting edge.
- R4: For every hop from the source toward the destination, the sequencer issues a precharge of the receiving subarray and then a move into it. Moves reach the receiving subarrays in order, one adjacent subarray per hop. In a move, `cmd_sub` is the receiving subarray and `cmd_dir` is 1 when data moves toward a higher subarray index.
- R5: After the move into the destination subarray, the next command is an activate of the destination subarray and row.
- R6: After the destination activate, one precharge is issued for each subarray from the source to the destination inclusive, in that order.
- R7: The next command follows an activate after `t_act` cycles, a precharge after `t_pre` cycles and a move after `t_hop` cycles; a span of 0 behaves as 1.
- R8: `done` is a one-cycle pulse `t_pre` cycles after the final precharge. `busy` falls and `req_ready` rises in that same cycle.
- R9: While reset is held, and right after it is released, `busy`, `done`, `err` and `cmd_valid` are 0 and `req_ready` is 1.
- R10: `cmd_op` encodes activate as 0, move as 1 and precharge as 2. When `cmd_valid` is 0, `cmd_op`, `cmd_sub`, `cmd_row` and `cmd_dir` are all 0. In precharge and move commands `cmd_row` is 0, and `cmd_dir` is 0 in every command other than a move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Copy request strobe |
| req_ready | output | 1 | High when a request can be taken |
| req_src_sub | input | SUB_W | Source subarray index |
| req_src_row | input | ROW_W | Source row index |
| req_dst_sub | input | SUB_W | Destination subarray index |
| req_dst_row | input | ROW_W | Destination row index |
| t_act | input | CNT_W | Activation span in cycles |
| t_pre | input | CNT_W | Precharge span in cycles |
| t_hop | input | CNT_W | Link hop span in cycles |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 2 | Command code: 0 activate, 1 move, 2 precharge |
| cmd_sub | output | SUB_W | Target subarray (receiving subarray for a move) |
| cmd_row | output | ROW_W | Row for an activate, else 0 |
| cmd_dir | output | 1 | Move direction, 1 toward higher index |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle pulse at the end of a copy |
| err | output | 1 | One-cycle pulse for a refused request |

## Verification
A corrupted hop pointer shows on the next precharge or move as a wrong `cmd_sub`, so it is visible within one span of the fault. A corrupted phase shows as a command of the wrong code, or as a missing or extra command at the next expiry. A timer fault moves the cycle stamp of the very next command, and every later one, by the same amount. Because each command is compared by its code, target, row, direction and exact cycle, and done is compared by its cycle, any such fault appears at the ports within one programmed span.

// File: rtl/rowcopy_pkg.sv
package rowcopy_pkg;

   // Command codes on the bank command bus
   typedef enum logic [1:0] {
      OP_ACT  = 2'd0,
      OP_MOVE = 2'd1,
      OP_PRE  = 2'd2
   } row_op_e;

   // Steps of one copy after the source activate
   typedef enum logic [2:0] {
      PH_HOP_PRE = 3'd0,
      PH_MOVE    = 3'd1,
      PH_ACT_DST = 3'd2,
      PH_CLOSE   = 3'd3,
      PH_END     = 3'd4
   } copy_phase_e;

endpackage

// File: rtl/rowcopy_gap_timer.sv
module rowcopy_gap_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] span,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= (span == '0) ? '0 : span - 1'b1;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // R7
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R7
   load_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && span > 1) |=> !expired);

endmodule

// File: rtl/rowcopy_hop_walker.sv
module rowcopy_hop_walker #(
   parameter int SUB_W = 3
) (
   input  logic [SUB_W-1:0] cur,
   input  logic [SUB_W-1:0] target,
   input  logic             up,
   output logic [SUB_W-1:0] step,
   output logic             at_target
);

   always_comb begin
      step      = up ? cur + 1'b1 : cur - 1'b1;
      at_target = (cur == target);
   end

endmodule

// File: rtl/rowcopy_seq.sv
module rowcopy_seq
   import rowcopy_pkg::*;
#(
   parameter int NUM_SUBARRAYS = 8,
   parameter int ROWS_PER_SUB  = 512,
   parameter int CNT_W         = 8,
   localparam int SUB_W        = $clog2(NUM_SUBARRAYS),
   localparam int ROW_W        = $clog2(ROWS_PER_SUB)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [SUB_W-1:0] req_src_sub,
   input  logic [ROW_W-1:0] req_src_row,
   input  logic [SUB_W-1:0] req_dst_sub,
   input  logic [ROW_W-1:0] req_dst_row,
   input  logic [CNT_W-1:0] t_act,
   input  logic [CNT_W-1:0] t_pre,
   input  logic [CNT_W-1:0] t_hop,
   output logic             cmd_valid,
   output logic [1:0]       cmd_op,
   output logic [SUB_W-1:0] cmd_sub,
   output logic [ROW_W-1:0] cmd_row,
   output logic             cmd_dir,
   output logic             busy,
   output logic             done,
   output logic             err
);

   generate
      if (NUM_SUBARRAYS < 2) begin : g_bad_subs
         $error("rowcopy_seq needs at least two subarrays");
      end
      if (ROWS_PER_SUB < 2) begin : g_bad_rows
         $error("rowcopy_seq needs at least two rows per subarray");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("rowcopy_seq span counter width must be positive");
      end
   endgenerate

   // Copy context
   logic             busy_q, done_q, err_q, up_q;
   copy_phase_e      phase_q, phase_n;
   logic [SUB_W-1:0] cur_q, cur_n, src_q, dst_q;
   logic [ROW_W-1:0] drow_q;

   // Registered command bus
   logic             cv_q, dir_q;
   row_op_e          op_q;
   logic [SUB_W-1:0] sub_q;
   logic [ROW_W-1:0] row_q;

   // Next-command decode
   logic             emit, fin, start, refuse;
   row_op_e          e_op;
   logic [SUB_W-1:0] e_sub;
   logic [ROW_W-1:0] e_row;
   logic             e_dir;
   logic [CNT_W-1:0] e_span;

   logic             tmr_expired;
   logic [SUB_W-1:0] step_sub;
   logic             at_dst;

   rowcopy_gap_timer #(.CNT_W(CNT_W)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (emit),
      .span    (e_span),
      .expired (tmr_expired)
   );

   rowcopy_hop_walker #(.SUB_W(SUB_W)) i_walker (
      .cur       (cur_q),
      .target    (dst_q),
      .up        (up_q),
      .step      (step_sub),
      .at_target (at_dst)
   );

   assign start  = !busy_q && req_valid && (req_src_sub != req_dst_sub);
   assign refuse = !busy_q && req_valid && (req_src_sub == req_dst_sub);

   always_comb begin
      emit    = 1'b0;
      fin     = 1'b0;
      e_op    = OP_ACT;
      e_sub   = '0;
      e_row   = '0;
      e_dir   = 1'b0;
      e_span  = '0;
      phase_n = phase_q;
      cur_n   = cur_q;
      if (!busy_q) begin
         if (start) begin
            emit    = 1'b1;
            e_op    = OP_ACT;
            e_sub   = req_src_sub;
            e_row   = req_src_row;
            e_span  = t_act;
            phase_n = PH_HOP_PRE;
            cur_n   = req_src_sub;
         end
      end else if (tmr_expired) begin
         case (phase_q)
            PH_HOP_PRE: begin
               emit    = 1'b1;
               e_op    = OP_PRE;
               e_sub   = step_sub;
               e_span  = t_pre;
               cur_n   = step_sub;
               phase_n = PH_MOVE;
            end
            PH_MOVE: begin
               emit    = 1'b1;
               e_op    = OP_MOVE;
               e_sub   = cur_q;
               e_dir   = up_q;
               e_span  = t_hop;
               phase_n = at_dst ? PH_ACT_DST : PH_HOP_PRE;
            end
            PH_ACT_DST: begin
               emit    = 1'b1;
               e_op    = OP_ACT;
               e_sub   = dst_q;
               e_row   = drow_q;
               e_span  = t_act;
               cur_n   = src_q;
               phase_n = PH_CLOSE;
            end
            PH_CLOSE: begin
               emit    = 1'b1;
               e_op    = OP_PRE;
               e_sub   = cur_q;
               e_span  = t_pre;
               if (at_dst) begin
                  phase_n = PH_END;
               end else begin
                  cur_n = step_sub;
               end
            end
            PH_END: begin
               fin = 1'b1;
            end
            default: begin
               fin = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         up_q    <= 1'b0;
         phase_q <= PH_END;
         cur_q   <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         drow_q  <= '0;
         cv_q    <= 1'b0;
         op_q    <= OP_ACT;
         sub_q   <= '0;
         row_q   <= '0;
         dir_q   <= 1'b0;
      end else begin
         cv_q    <= emit;
         op_q    <= e_op;
         sub_q   <= e_sub;
         row_q   <= e_row;
         dir_q   <= e_dir;
         done_q  <= fin;
         err_q   <= refuse;
         phase_q <= phase_n;
         cur_q   <= cur_n;
         if (start) begin
            busy_q <= 1'b1;
            src_q  <= req_src_sub;
            dst_q  <= req_dst_sub;
            drow_q <= req_dst_row;
            up_q   <= (req_dst_sub > req_src_sub);
         end else if (fin) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign req_ready = !busy_q;
   assign busy      = busy_q;
   assign done      = done_q;
   assign err       = err_q;
   assign cmd_valid = cv_q;
   assign cmd_op    = op_q;
   assign cmd_sub   = sub_q;
   assign cmd_row   = row_q;
   assign cmd_dir   = dir_q;

   // R3
   start_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (cv_q && op_q == OP_ACT && sub_q == src_q));

   // R3
   cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cv_q |-> busy_q);

   // R2
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (!busy_q && !cv_q));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!busy_q && !cv_q && $past(busy_q)));

   // R4
   move_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cv_q && op_q == OP_MOVE) |-> (sub_q != src_q));

   // R10
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cv_q |-> (op_q == OP_ACT && sub_q == '0 && row_q == '0 && !dir_q));

endmodule

// File: tb/test_rowcopy_seq.sv
module test_rowcopy_seq;

   localparam int NSUB  = 8;
   localparam int SUB_W = 3;
   localparam int ROW_W = 9;
   localparam int CNT_W = 8;

   typedef struct packed {
      logic [2:0] src;
      logic [8:0] srow;
      logic [2:0] dst;
      logic [8:0] drow;
      logic [7:0] ta;
      logic [7:0] tp;
      logic [7:0] th;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{3'd0, 9'd17,  3'd1, 9'd300, 8'd5,  8'd4,  8'd2},
      '{3'd5, 9'd0,   3'd2, 9'd511, 8'd3,  8'd2,  8'd1},
      '{3'd0, 9'd511, 3'd7, 9'd0,   8'd2,  8'd2,  8'd1},
      '{3'd7, 9'd100, 3'd6, 9'd101, 8'd0,  8'd0,  8'd0},
      '{3'd3, 9'd42,  3'd5, 9'd43,  8'd1,  8'd1,  8'd1},
      '{3'd6, 9'd256, 3'd0, 9'd1,   8'd50, 8'd50, 8'd3}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [SUB_W-1:0] req_src_sub = '0;
   logic [ROW_W-1:0] req_src_row = '0;
   logic [SUB_W-1:0] req_dst_sub = '0;
   logic [ROW_W-1:0] req_dst_row = '0;
   logic [CNT_W-1:0] t_act = 8'd1;
   logic [CNT_W-1:0] t_pre = 8'd1;
   logic [CNT_W-1:0] t_hop = 8'd1;
   logic             cmd_valid;
   logic [1:0]       cmd_op;
   logic [SUB_W-1:0] cmd_sub;
   logic [ROW_W-1:0] cmd_row;
   logic             cmd_dir;
   logic             busy, done, err;

   rowcopy_seq #(.NUM_SUBARRAYS(NSUB), .ROWS_PER_SUB(512), .CNT_W(CNT_W)) i_rowcopy_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_src_sub (req_src_sub),
      .req_src_row (req_src_row),
      .req_dst_sub (req_dst_sub),
      .req_dst_row (req_dst_row),
      .t_act       (t_act),
      .t_pre       (t_pre),
      .t_hop       (t_hop),
      .cmd_valid   (cmd_valid),
      .cmd_op      (cmd_op),
      .cmd_sub     (cmd_sub),
      .cmd_row     (cmd_row),
      .cmd_dir     (cmd_dir),
      .busy        (busy),
      .done        (done),
      .err         (err)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   // Command log filled at the falling edge
   int log_n = 0;
   int log_cyc [64];
   int log_code [64];
   int done_cyc = -1;
   int err_cnt = 0;
   int quiet_bad = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_valid) begin
            if (log_n < 64) begin
               log_cyc[log_n]  = cyc;
               log_code[log_n] = int'(cmd_op) * 100000 + int'(cmd_sub) * 1000
                                 + int'(cmd_row) * 2 + int'(cmd_dir);
            end
            log_n = log_n + 1;
         end else if (cmd_op != 2'd0 || cmd_sub != '0 || cmd_row != '0 || cmd_dir) begin
            quiet_bad = quiet_bad + 1;
         end
         if (done) done_cyc = cyc;
         if (err) err_cnt = err_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int code(input int op, input int sub, input int row, input int dir);
      return op * 100000 + sub * 1000 + row * 2 + dir;
   endfunction

   function automatic int gap(input int t);
      return (t == 0) ? 1 : t;
   endfunction

   task automatic run_copy(input vec_t v, input bit hold_busy);
      int    exp_code [64];
      int    exp_cyc [64];
      string exp_tag [64];
      int    n, k, s, d, dir, acc, guard, ne, last_gap, exp_done;
      s   = int'(v.src);
      d   = int'(v.dst);
      dir = (d > s) ? 1 : -1;
      n   = (d > s) ? d - s : s - d;
      ne  = 0;
      exp_code[ne] = code(0, s, int'(v.srow), 0); exp_tag[ne] = "R3";
      exp_cyc[ne] = 0; last_gap = gap(int'(v.ta)); ne++;
      for (int h = 1; h <= n; h++) begin
         exp_code[ne] = code(2, s + dir * h, 0, 0); exp_tag[ne] = "R4";
         exp_cyc[ne] = exp_cyc[ne-1] + last_gap; last_gap = gap(int'(v.tp)); ne++;
         exp_code[ne] = code(1, s + dir * h, 0, (dir > 0) ? 1 : 0); exp_tag[ne] = "R4";
         exp_cyc[ne] = exp_cyc[ne-1] + last_gap; last_gap = gap(int'(v.th)); ne++;
      end
      exp_code[ne] = code(0, d, int'(v.drow), 0); exp_tag[ne] = "R5";
      exp_cyc[ne] = exp_cyc[ne-1] + last_gap; last_gap = gap(int'(v.ta)); ne++;
      for (int h = 0; h <= n; h++) begin
         exp_code[ne] = code(2, s + dir * h, 0, 0); exp_tag[ne] = "R6";
         exp_cyc[ne] = exp_cyc[ne-1] + last_gap; last_gap = gap(int'(v.tp)); ne++;
      end
      exp_done = exp_cyc[ne-1] + last_gap;

      log_n = 0;
      done_cyc = -1;
      @(negedge clk);
      req_valid   = 1'b1;
      req_src_sub = v.src;  req_src_row = v.srow;
      req_dst_sub = v.dst;  req_dst_row = v.drow;
      t_act = v.ta; t_pre = v.tp; t_hop = v.th;
      @(posedge clk);
      #1 acc = cyc;
      @(negedge clk);
      if (hold_busy) begin
         // R1: a second request held during the copy must be ignored
         req_src_sub = 3'd2; req_dst_sub = 3'd4; req_src_row = 9'd9; req_dst_row = 9'd8;
         check(req_ready == 1'b0, "R1", "ready while busy", int'(req_ready), 0);
         for (int i = 0; i < 15; i++) @(negedge clk);
         req_valid = 1'b0;
      end else begin
         req_valid = 1'b0;
      end
      guard = 0;
      while (done_cyc < 0 && guard < 5000) begin
         @(posedge clk);
         guard++;
      end
      for (int i = 0; i < 3; i++) @(negedge clk);

      check(log_n == ne, "R4", "command count", log_n, ne);
      k = (log_n < ne) ? log_n : ne;
      for (int i = 0; i < k; i++) begin
         check(log_code[i] == exp_code[i], exp_tag[i], "command fields",
               log_code[i], exp_code[i]);
         check(log_cyc[i] - acc == exp_cyc[i], "R7", "command cycle",
               log_cyc[i] - acc, exp_cyc[i]);
      end
      check(done_cyc - acc == exp_done, "R8", "done cycle", done_cyc - acc, exp_done);
      check(busy == 1'b0 && req_ready == 1'b1, "R8", "idle after done",
            int'(busy), 0);
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int acc;
      // R9: reset state
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0 && err == 0 && cmd_valid == 0, "R9",
            "outputs in reset", int'({busy, done, err, cmd_valid}), 0);
      check(req_ready == 1'b1, "R9", "ready in reset", int'(req_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 0 && done == 0 && err == 0 && cmd_valid == 0 && req_ready == 1,
            "R9", "outputs after reset", int'({busy, done, err, cmd_valid, req_ready}), 1);

      // Vector table walk
      for (int i = 0; i < NVEC; i++) begin
         run_copy(VECS[i], 1'b0);
      end

      // R1: request held during a long copy
      run_copy(VECS[5], 1'b1);

      // R2: same subarray is refused
      log_n = 0;
      err_cnt = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_src_sub = 3'd4; req_dst_sub = 3'd4;
      req_src_row = 9'd3; req_dst_row = 9'd5;
      @(posedge clk);
      #1 acc = cyc;
      @(negedge clk);
      req_valid = 1'b0;
      check(err == 1'b1, "R2", "err pulse", int'(err), 1);
      check(busy == 1'b0, "R2", "busy after refusal", int'(busy), 0);
      for (int i = 0; i < 10; i++) @(negedge clk);
      check(err_cnt == 1, "R2", "err pulse count", err_cnt, 1);
      check(log_n == 0, "R2", "commands after refusal", log_n, 0);

      // R10: bus quiet between commands
      check(quiet_bad == 0, "R10", "idle bus fields", quiet_bad, 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule